// File: doc/BRIEF.md
# Multicycle RISC Instruction Sequencer

This block is a compact processor core that runs 32-bit fixed-format instructions over several clock cycles each. It pairs a controller state machine with a small datapath: a program counter, an instruction register, two operand latches, a result latch, an ALU and a 32-entry register file kept inside the block. One memory port serves both instruction fetches and data accesses. The memory is synchronous: an address presented in one cycle returns its word on `mem_rdata_i` in the next cycle, and a write takes effect at the end of the cycle in which `mem_we_o` is high.

Every instruction starts with the same three steps: a fetch request, instruction capture with PC+4, and decode with operand read. After decode the controller takes a separate path for each instruction class, so each class uses only the steps it needs. Register-register and register-immediate operations take 5 cycles, loads 6, stores 5, branches and jumps 4, and unrecognised encodings 3. `done_o` pulses high in the last cycle of every instruction, so a host can count retired instructions.

Top module: `mc_seq_core`

## Requirements
- R1: While `rst_n` is low, `done_o` and `mem_we_o` are low and `mem_addr_o` equals the reset PC (0). The first fetch after reset reads address 0.
- R2: Each instruction is read from memory at the current PC, and PC then advances by 4. Fields: opcode [31:26], source A [25:21], source B or immediate destination [20:16], register-register destination [15:11], function [10:0], immediate [15:0], jump target [25:0]. Cycle counts: register-register and register-immediate 5, load 6, store 5, branch and jump 4, unrecognised 3.
- R3: Register 0 always reads as zero. Writes to it, from either an ALU form or a load, are discarded.
- R4: Opcode 0x00 computes A op B into the register in [15:11]. Function 0x020 is add, 0x022 subtract, 0x024 AND, 0x025 OR, 0x026 XOR, and 0x02A signed set-less-than (1 or 0).
- R5: Register-immediate forms write to the register in [20:16]. Opcode 0x08 is add and 0x0A is signed set-less-than, both with a sign-extended immediate. Opcodes 0x0C AND, 0x0D OR and 0x0E XOR use a zero-extended immediate.
- R6: Opcode 0x23 loads the word at (A + sign-extended immediate) into register [20:16]. The data address appears on `mem_addr_o` in the 5th cycle of the instruction.
- R7: Opcode 0x2B writes B to address (A + sign-extended immediate). `mem_we_o` is high for exactly one cycle, the 5th and last cycle of the store, and no register changes.
- R8: Opcode 0x04 (branch if A equals B) and opcode 0x05 (branch if A differs from B) set PC to PC+4 + (sign-extended immediate << 2) when the condition holds. Otherwise PC stays at PC+4.
- R9: Opcode 0x02 replaces PC bits [27:2] with the target field and clears bits [1:0]. PC bits [31:28] are kept from PC+4.
- R10: An unrecognised opcode, or opcode 0x00 with an unlisted function code, changes no register and no memory word. It retires after 3 cycles, and the next fetch is at PC+4.
- R11: `done_o` is high for exactly one cycle per instruction, in that instruction's last cycle, and never in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr_o | output | 32 | Byte address for fetch, load or store |
| mem_wdata_o | output | 32 | Store data |
| mem_we_o | output | 1 | Memory write enable |
| mem_rdata_i | input | 32 | Word read at the address from the previous cycle |
| done_o | output | 1 | One-cycle pulse when an instruction retires |

## Verification
The test program mixes positive and negative operands. Signed and unsigned set-less-than give different results on these values, and so do sign- and zero-extended immediates. It also writes to register 0 through both an ALU form and a load, to show such writes are discarded. Branches are tried in both polarities, taken and not taken. A countdown loop exercises a negative branch offset, and a load with a negative displacement checks the address adder. Two unrecognised encodings name live registers in their fields, so any stray write shows up when every register is finally stored to memory.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
    localparam int XLEN    = 32;
    localparam int REG_CNT = 32;

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_JMP   = 6'h02;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] OP_BNE   = 6'h05;
    localparam logic [5:0] OP_ADDI  = 6'h08;
    localparam logic [5:0] OP_SLTI  = 6'h0A;
    localparam logic [5:0] OP_ANDI  = 6'h0C;
    localparam logic [5:0] OP_ORI   = 6'h0D;
    localparam logic [5:0] OP_XORI  = 6'h0E;
    localparam logic [5:0] OP_LW    = 6'h23;
    localparam logic [5:0] OP_SW    = 6'h2B;

    localparam logic [10:0] FN_ADD = 11'h020;
    localparam logic [10:0] FN_SUB = 11'h022;
    localparam logic [10:0] FN_AND = 11'h024;
    localparam logic [10:0] FN_OR  = 11'h025;
    localparam logic [10:0] FN_XOR = 11'h026;
    localparam logic [10:0] FN_SLT = 11'h02A;

    typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_SLT} alu_op_e;

    typedef enum logic [2:0] {CL_RR, CL_RI, CL_LD, CL_ST, CL_BR, CL_JMP, CL_BAD} iclass_e;

    typedef enum logic [3:0] {
        S_IF_REQ, S_IF_LAT, S_DECODE, S_EX_RR, S_EX_RI, S_ADDR,
        S_MEM_RD, S_MEM_WR, S_LD_WB, S_ALU_WB, S_BRANCH, S_JUMP
    } state_e;

    typedef struct packed {
        iclass_e    cls;
        alu_op_e    op;
        logic       imm_zext;
        logic       br_ne;
        logic [4:0] dst;
    } dec_t;

    typedef struct packed {
        state_e            st;
        logic [XLEN-1:0]   pc;
        logic [XLEN-1:0]   ir;
        logic [XLEN-1:0]   a;
        logic [XLEN-1:0]   b;
        logic [XLEN-1:0]   res;
    } core_regs_t;
endpackage

// File: rtl/mcs_regfile.sv
module mcs_regfile #(
    parameter int W     = 32,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);
    logic [W-1:0] ent [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
        if (gi == 0) begin : g_zero
            assign ent[gi] = '0;
        end else begin : g_reg
            logic [W-1:0] val_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    val_q <= '0;
                else if (we && wa == AW'(gi))
                    val_q <= wd;
            end
            assign ent[gi] = val_q;
        end
    end

    assign rd_a = ent[ra_a];
    assign rd_b = ent[ra_b];
endmodule

// File: rtl/mcs_decode.sv
module mcs_decode
    import mcs_pkg::*;
(
    input  logic [5:0]  opcode,
    input  logic [10:0] funct,
    input  logic [4:0]  rt_fld,
    input  logic [4:0]  rd_fld,
    output dec_t        dec
);
    always_comb begin
        dec          = '0;
        dec.cls      = CL_BAD;
        dec.op       = ALU_ADD;
        dec.dst      = rt_fld;
        case (opcode)
            OP_RTYPE: begin
                dec.cls = CL_RR;
                dec.dst = rd_fld;
                case (funct)
                    FN_ADD:  dec.op = ALU_ADD;
                    FN_SUB:  dec.op = ALU_SUB;
                    FN_AND:  dec.op = ALU_AND;
                    FN_OR:   dec.op = ALU_OR;
                    FN_XOR:  dec.op = ALU_XOR;
                    FN_SLT:  dec.op = ALU_SLT;
                    default: dec.cls = CL_BAD;
                endcase
            end
            OP_ADDI: begin dec.cls = CL_RI; dec.op = ALU_ADD; end
            OP_SLTI: begin dec.cls = CL_RI; dec.op = ALU_SLT; end
            OP_ANDI: begin dec.cls = CL_RI; dec.op = ALU_AND; dec.imm_zext = 1'b1; end
            OP_ORI:  begin dec.cls = CL_RI; dec.op = ALU_OR;  dec.imm_zext = 1'b1; end
            OP_XORI: begin dec.cls = CL_RI; dec.op = ALU_XOR; dec.imm_zext = 1'b1; end
            OP_LW:   dec.cls = CL_LD;
            OP_SW:   dec.cls = CL_ST;
            OP_BEQ:  dec.cls = CL_BR;
            OP_BNE:  begin dec.cls = CL_BR; dec.br_ne = 1'b1; end
            OP_JMP:  dec.cls = CL_JMP;
            default: dec.cls = CL_BAD;
        endcase
    end
endmodule

// File: rtl/mcs_alu.sv
module mcs_alu
    import mcs_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e      op,
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] r
);
    always_comb begin
        case (op)
            ALU_ADD: r = x + y;
            ALU_SUB: r = x - y;
            ALU_AND: r = x & y;
            ALU_OR:  r = x | y;
            ALU_XOR: r = x ^ y;
            ALU_SLT: r = ($signed(x) < $signed(y)) ? W'(1) : '0;
            default: r = '0;
        endcase
    end
endmodule

// File: rtl/mc_seq_core.sv
module mc_seq_core
    import mcs_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [31:0] mem_addr_o,
    output logic [31:0] mem_wdata_o,
    output logic        mem_we_o,
    input  logic [31:0] mem_rdata_i,
    output logic        done_o
);
    localparam int RAW = $clog2(REG_CNT);

    core_regs_t cq, cd;
    dec_t       dec;

    logic [XLEN-1:0] rf_rd_a, rf_rd_b, rf_wd;
    logic            rf_we;
    logic [RAW-1:0]  rf_wa;
    alu_op_e         alu_op;
    logic [XLEN-1:0] alu_x, alu_y, alu_r;
    logic [XLEN-1:0] simm, zimm, imm_ext;

    mcs_decode u_dec (
        .opcode (cq.ir[31:26]),
        .funct  (cq.ir[10:0]),
        .rt_fld (cq.ir[20:16]),
        .rd_fld (cq.ir[15:11]),
        .dec    (dec)
    );

    mcs_regfile #(.W(XLEN), .DEPTH(REG_CNT)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra_a  (cq.ir[25:21]),
        .ra_b  (cq.ir[20:16]),
        .rd_a  (rf_rd_a),
        .rd_b  (rf_rd_b),
        .we    (rf_we),
        .wa    (rf_wa),
        .wd    (rf_wd)
    );

    mcs_alu #(.W(XLEN)) u_alu (
        .op (alu_op),
        .x  (alu_x),
        .y  (alu_y),
        .r  (alu_r)
    );

    assign simm    = {{(XLEN-16){cq.ir[15]}}, cq.ir[15:0]};
    assign zimm    = {{(XLEN-16){1'b0}}, cq.ir[15:0]};
    assign imm_ext = dec.imm_zext ? zimm : simm;

    always_comb begin
        cd          = cq;
        rf_we       = 1'b0;
        rf_wa       = dec.dst;
        rf_wd       = cq.res;
        alu_op      = dec.op;
        alu_x       = cq.a;
        alu_y       = cq.b;
        mem_addr_o  = cq.pc;
        mem_wdata_o = cq.b;
        mem_we_o    = 1'b0;
        done_o      = 1'b0;
        case (cq.st)
            S_IF_REQ: cd.st = S_IF_LAT;
            S_IF_LAT: begin
                cd.ir = mem_rdata_i;
                cd.pc = cq.pc + 32'd4;
                cd.st = S_DECODE;
            end
            S_DECODE: begin
                cd.a = rf_rd_a;
                cd.b = rf_rd_b;
                case (dec.cls)
                    CL_RR:        cd.st = S_EX_RR;
                    CL_RI:        cd.st = S_EX_RI;
                    CL_LD, CL_ST: cd.st = S_ADDR;
                    CL_BR:        cd.st = S_BRANCH;
                    CL_JMP:       cd.st = S_JUMP;
                    default: begin
                        cd.st  = S_IF_REQ;
                        done_o = 1'b1;
                    end
                endcase
            end
            S_EX_RR: begin
                cd.res = alu_r;
                cd.st  = S_ALU_WB;
            end
            S_EX_RI: begin
                alu_y  = imm_ext;
                cd.res = alu_r;
                cd.st  = S_ALU_WB;
            end
            S_ADDR: begin
                alu_op = ALU_ADD;
                alu_y  = simm;
                cd.res = alu_r;
                cd.st  = (dec.cls == CL_LD) ? S_MEM_RD : S_MEM_WR;
            end
            S_MEM_RD: begin
                mem_addr_o = cq.res;
                cd.st      = S_LD_WB;
            end
            S_LD_WB: begin
                rf_we  = 1'b1;
                rf_wd  = mem_rdata_i;
                done_o = 1'b1;
                cd.st  = S_IF_REQ;
            end
            S_MEM_WR: begin
                mem_addr_o = cq.res;
                mem_we_o   = 1'b1;
                done_o     = 1'b1;
                cd.st      = S_IF_REQ;
            end
            S_ALU_WB: begin
                rf_we  = 1'b1;
                done_o = 1'b1;
                cd.st  = S_IF_REQ;
            end
            S_BRANCH: begin
                if ((cq.a == cq.b) ^ dec.br_ne)
                    cd.pc = cq.pc + {simm[XLEN-3:0], 2'b00};
                done_o = 1'b1;
                cd.st  = S_IF_REQ;
            end
            S_JUMP: begin
                cd.pc  = {cq.pc[31:28], cq.ir[25:0], 2'b00};
                done_o = 1'b1;
                cd.st  = S_IF_REQ;
            end
            default: cd.st = S_IF_REQ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cq     <= '0;
            cq.st  <= S_IF_REQ;
            cq.pc  <= RESET_PC;
        end else begin
            cq <= cd;
        end
    end
endmodule

// File: rtl/mcs_chk.sv
module mcs_chk
    import mcs_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        done,
    input logic        mem_we,
    input state_e      st,
    input logic [31:0] pc,
    input logic [31:0] ir,
    input logic [31:0] a,
    input logic [31:0] b
);
    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    store_retires_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> done);

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IF_LAT) |=> (pc == $past(pc) + 32'd4));

    // R3
    zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_DECODE && ir[25:21] == 5'd0) |=> (a == 32'd0));

    // R8
    branch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_BRANCH && ir[31:26] == OP_BEQ && a != b) |=> $stable(pc));

    // R9
    jump_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_JUMP) |=> (pc[31:28] == $past(pc[31:28]) && pc[1:0] == 2'b00));
endmodule

bind mc_seq_core mcs_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .done   (done_o),
    .mem_we (mem_we_o),
    .st     (cq.st),
    .pc     (cq.pc),
    .ir     (cq.ir),
    .a      (cq.a),
    .b      (cq.b)
);

// File: tb/mc_seq_core_tb_top.sv
module mc_seq_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
    logic        mem_we_o, done_o;

    always #4 clk = ~clk;

    mc_seq_core dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .mem_we_o    (mem_we_o),
        .mem_rdata_i (mem_rdata_i),
        .done_o      (done_o)
    );

    logic [31:0] dmem [256];
    logic [31:0] mm   [256];
    logic [31:0] rm   [32];
    string       src_tag [32];

    always @(posedge clk) begin
        if (mem_we_o) dmem[mem_addr_o[9:2]] <= mem_wdata_o;
        mem_rdata_i <= dmem[mem_addr_o[9:2]];
    end

    int checks = 0, failures = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // program assembly helpers
    int pi = 0;
    task automatic put(input logic [31:0] w);
        dmem[pi] = w;
        pi++;
    endtask
    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [10:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), fn};
    endfunction
    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction
    function automatic logic [31:0] enc_j(input int idx);
        return {6'h02, 26'(idx)};
    endfunction

    // reference model state
    logic [31:0] pc_m = 32'h0, cur_pc = 32'h0;
    logic [31:0] exp_sa, exp_sd, exp_la;
    logic        exp_st = 1'b0, is_ld = 1'b0, halt = 1'b0, finished = 1'b0;
    int          cnt = 0, len = 3;
    string       tag_pc = "R1", st_tag = "R7";

    task model_step();
        logic [31:0] w, si, zi, v;
        logic [5:0]  op;
        logic [4:0]  rs, rt, rd, dst;
        logic [10:0] fn;
        logic        wr;
        string       wt;
        w  = mm[cur_pc[9:2]];
        op = w[31:26]; rs = w[25:21]; rt = w[20:16]; rd = w[15:11]; fn = w[10:0];
        si = {{16{w[15]}}, w[15:0]};
        zi = {16'h0, w[15:0]};
        pc_m = cur_pc + 32'd4;
        len = 3; exp_st = 1'b0; is_ld = 1'b0; wr = 1'b0; dst = rt; v = 0;
        wt = "R5"; tag_pc = "R2"; halt = 1'b0;
        case (op)
            6'h00: begin
                len = 5; wr = 1'b1; dst = rd; wt = "R4";
                case (fn)
                    11'h020: v = rm[rs] + rm[rt];
                    11'h022: v = rm[rs] - rm[rt];
                    11'h024: v = rm[rs] & rm[rt];
                    11'h025: v = rm[rs] | rm[rt];
                    11'h026: v = rm[rs] ^ rm[rt];
                    11'h02A: v = ($signed(rm[rs]) < $signed(rm[rt])) ? 32'd1 : 32'd0;
                    default: begin len = 3; wr = 1'b0; end
                endcase
            end
            6'h08: begin len = 5; wr = 1'b1; v = rm[rs] + si; end
            6'h0A: begin len = 5; wr = 1'b1; v = ($signed(rm[rs]) < $signed(si)) ? 32'd1 : 32'd0; end
            6'h0C: begin len = 5; wr = 1'b1; v = rm[rs] & zi; end
            6'h0D: begin len = 5; wr = 1'b1; v = rm[rs] | zi; end
            6'h0E: begin len = 5; wr = 1'b1; v = rm[rs] ^ zi; end
            6'h23: begin
                len = 6; is_ld = 1'b1; exp_la = rm[rs] + si;
                v = mm[exp_la[9:2]]; wr = 1'b1; wt = "R6";
            end
            6'h2B: begin
                len = 5; exp_st = 1'b1; exp_sa = rm[rs] + si; exp_sd = rm[rt];
                st_tag = src_tag[rt];
                mm[exp_sa[9:2]] = exp_sd;
            end
            6'h04, 6'h05: begin
                len = 4; tag_pc = "R8";
                if ((rm[rs] == rm[rt]) == (op == 6'h04))
                    pc_m = cur_pc + 32'd4 + {si[29:0], 2'b00};
            end
            6'h02: begin
                len = 4; tag_pc = "R9";
                pc_m = {pc_m[31:28], w[25:0], 2'b00};
                halt = (pc_m == cur_pc);
            end
            default: ;
        endcase
        if (len == 3) begin
            tag_pc = "R10";
            if (rt != 0) src_tag[rt] = "R10";
            if (rd != 0) src_tag[rd] = "R10";
        end
        if (wr) begin
            if (dst != 0) begin
                rm[dst] = v;
                src_tag[dst] = wt;
            end else begin
                src_tag[0] = "R3";
            end
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            chk(done_o == 1'b0, "R1", "done during reset", {31'b0, done_o}, 32'd0);
            chk(mem_we_o == 1'b0, "R1", "write enable during reset", {31'b0, mem_we_o}, 32'd0);
            chk(mem_addr_o == 32'h0, "R1", "address during reset", mem_addr_o, 32'h0);
        end else if (!finished) begin
            if (cnt == 0) begin
                cur_pc = pc_m;
                chk(mem_addr_o == cur_pc, tag_pc, "fetch address", mem_addr_o, cur_pc);
                model_step();
            end
            chk(done_o == ((cnt == len - 1) ? 1'b1 : 1'b0), "R11", "done timing",
                {31'b0, done_o}, {31'b0, (cnt == len - 1)});
            chk(mem_we_o == ((exp_st && cnt == len - 1) ? 1'b1 : 1'b0), "R7", "write enable",
                {31'b0, mem_we_o}, {31'b0, (exp_st && cnt == len - 1)});
            if (exp_st && cnt == len - 1) begin
                chk(mem_addr_o == exp_sa, "R7", "store address", mem_addr_o, exp_sa);
                chk(mem_wdata_o == exp_sd, st_tag, "store data", mem_wdata_o, exp_sd);
            end
            if (is_ld && cnt == 4)
                chk(mem_addr_o == exp_la, "R6", "load address", mem_addr_o, exp_la);
            cnt++;
            if (cnt == len) begin
                cnt = 0;
                if (halt) finished = 1'b1;
            end
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) dmem[i] = 32'h0;
        for (int i = 0; i < 32; i++) begin rm[i] = 32'h0; src_tag[i] = "R3"; end
        // R5: immediates with sign extension
        put(enc_i(6'h08, 0, 1, 16'h0005));
        put(enc_i(6'h08, 0, 2, 16'hFFFD));
        // R4: register-register operations on mixed signs
        put(enc_r(1, 2, 3, 11'h020));
        put(enc_r(1, 2, 4, 11'h022));
        put(enc_r(1, 2, 5, 11'h024));
        put(enc_r(1, 2, 6, 11'h025));
        put(enc_r(1, 2, 7, 11'h026));
        put(enc_r(2, 1, 8, 11'h02A));
        put(enc_r(1, 2, 18, 11'h02A));
        // R5: zero-extended logic immediates, signed compare
        put(enc_i(6'h0C, 2, 9, 16'hFFFF));
        put(enc_i(6'h0D, 0, 10, 16'h8001));
        put(enc_i(6'h0E, 1, 11, 16'h000F));
        put(enc_i(6'h0A, 2, 12, 16'hFFFF));
        put(enc_i(6'h0A, 1, 19, 16'h8000));
        // R3: writes to register 0
        put(enc_i(6'h08, 0, 0, 16'h0007));
        put(enc_r(1, 1, 0, 11'h020));
        // R7 / R6: stores, loads, negative displacement, load into r0
        put(enc_i(6'h2B, 0, 1, 16'h0300));
        put(enc_i(6'h2B, 0, 2, 16'h0304));
        put(enc_i(6'h08, 0, 15, 16'h030C));
        put(enc_i(6'h23, 0, 13, 16'h0300));
        put(enc_i(6'h23, 15, 14, 16'hFFF8));
        put(enc_i(6'h23, 15, 0, 16'hFFF4));
        put(enc_r(13, 14, 16, 11'h020));
        // R8: both polarities, taken and not taken
        put(enc_i(6'h04, 1, 1, 16'h0001));
        put(enc_i(6'h08, 0, 20, 16'h0BAD));
        put(enc_i(6'h04, 1, 2, 16'h0001));
        put(enc_i(6'h08, 0, 21, 16'h0011));
        put(enc_i(6'h05, 1, 1, 16'h0001));
        put(enc_i(6'h08, 0, 22, 16'h0022));
        put(enc_i(6'h05, 1, 2, 16'h0001));
        put(enc_i(6'h08, 0, 23, 16'h0BAD));
        // R8: backward loop
        put(enc_i(6'h08, 0, 17, 16'h0003));
        put(enc_i(6'h08, 17, 17, 16'hFFFF));
        put(enc_i(6'h08, 24, 24, 16'h0001));
        put(enc_i(6'h05, 17, 0, 16'hFFFD));
        // R10: unrecognised opcode and function
        put({6'h3F, 5'd3, 5'd1, 5'd2, 11'h000});
        put(enc_r(1, 1, 3, 11'h03F));
        // R9: forward jump over a marker
        put(enc_j(pi + 2));
        put(enc_i(6'h08, 0, 25, 16'h0BAD));
        // dump all registers
        for (int k = 0; k < 26; k++) put(enc_i(6'h2B, 0, k, 16'(32'h340 + 4 * k)));
        put(enc_j(pi));
        for (int i = 0; i < 256; i++) mm[i] = dmem[i];

        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        for (int cyc = 0; cyc < 20000 && !finished; cyc++) @(posedge clk);
        @(negedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL R11 watchdog: actual=%h expected=%h", 32'd0, 32'd1);
        end else begin
            for (int i = 0; i < 256; i++)
                chk(dmem[i] == mm[i], "R7", "final memory word", dmem[i], mm[i]);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule